// File: doc/BRIEF.md
# Programmable Input Spike Filter

This block cleans up the clock line and the data line of a serial host port before they reach the SPI or I2C protocol engines. Each raw pin is brought into the fast system clock domain through a two-flop synchronizer. A per-line stability counter then moves the filtered output to a new level only when that level has been held long enough. A two-bit mode register picks one of three rejection widths, expressed as system-clock cycle counts set by parameters, or a bypass path that adds no delay beyond the synchronizer.

Changing the spike width, the I2C-select control or the clock-polarity control disturbs the filtered lines. For this reason the block also drives a `settled` flag. The flag falls on any such change and stays low for a fixed multiple of the selected width, so the port can be held disabled until the lines are trustworthy. A hardware reset and a software reset both return the block to bypass with idle-high outputs.

Top module: `spike_filter`

## Requirements
- R1: While `rst_n` is low, both filtered outputs are 1 and `settled` is 1, whatever the raw pins do. The mode comes out of reset as 2'b00 (bypass).
- R2: A one-cycle `soft_rst` pulse has these effects in the cycle after it: both outputs are 1, `settled` is 1 and the mode is 2'b00. From then on the outputs follow the pins with the bypass latency.
- R3: With mode 2'b00 (bypass), each output equals its raw pin delayed by exactly two clock cycles. A one-cycle pulse on a pin reaches the output as a one-cycle pulse.
- R4: With mode 2'b01, a new pin level reaches the output only once the synchronized level has been sampled W_VNARROW+1 times in a row (default 2). The output changes W_VNARROW+3 cycles after the pin. Pulses of W_VNARROW cycles or fewer are dropped.
- R5: With mode 2'b10, the same rule applies with W_NARROW (default 5). A pulse broken by a single cycle at the old level starts its count again.
- R6: With mode 2'b11, the same rule applies with W_WIDE (default 10).
- R7: Loading a mode that is not bypass and differs from the current one drives `settled` low from the next cycle. It stays low for exactly SETTLE_MULT times the new width in cycles, default 10, 50 or 100, and then rises.
- R8: A change of `i2c_sel` or of `clk_pol` while a mode other than bypass is active lowers `settled` for the same window, measured from the cycle after the change.
- R9: In bypass mode `settled` stays 1, even when `i2c_sel` or `clk_pol` toggles.
- R10: A change that arrives in the last low cycle of a settle window restarts a full window. It does not let the flag rise.
- R11: `mode_wdata` has no effect unless `mode_load` is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| soft_rst | input | 1 | Synchronous software reset, active high |
| line_clk_in | input | 1 | Raw serial clock pin |
| line_dat_in | input | 1 | Raw serial data pin |
| mode_load | input | 1 | Strobe that writes `mode_wdata` into the mode register |
| mode_wdata | input | 2 | Filter mode: 00 bypass, 01 very narrow, 10 narrow, 11 wide |
| i2c_sel | input | 1 | Protocol select level from the host port |
| clk_pol | input | 1 | Serial clock polarity level from the host port |
| line_clk_out | output | 1 | Filtered serial clock |
| line_dat_out | output | 1 | Filtered serial data |
| settled | output | 1 | High when the filter is safe to use |

## Verification
Two events can fall in the same cycle: the settle timer expiring and a new configuration change, and they compete for the timer. The bench toggles `clk_pol` in very-narrow mode. It then toggles `i2c_sel` so that the toggle is sampled on exactly the edge where the ten-cycle window would close. It judges the result by requiring `settled` to stay low for a second full ten-cycle window before it rises. A checker also counts the low cycles before every rise of the flag and compares the count with the width of the active mode.

// File: rtl/spike_filter_pkg.sv
`timescale 1ns/1ps
package spike_filter_pkg;

  // Filter mode encoding; the register field decodes these values directly.
  typedef enum logic [1:0] {
    FM_BYPASS  = 2'b00,
    FM_VNARROW = 2'b01,
    FM_NARROW  = 2'b10,
    FM_WIDE    = 2'b11
  } fmode_e;

  localparam int unsigned LINE_CLK  = 0;
  localparam int unsigned LINE_DAT  = 1;
  localparam int unsigned NUM_LINES = 2;

endpackage

// File: rtl/sf_sync2.sv
`timescale 1ns/1ps
// Two-flop synchronizer per raw pin, idle-high on reset.
module sf_sync2 #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] meta_q, meta_d;
  logic [WIDTH-1:0] sync_q, sync_d;

  always_comb begin
    if (clr) begin
      meta_d = '1;
      sync_d = '1;
    end else begin
      meta_d = d;
      sync_d = meta_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      sync_q <= '1;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
    end
  end

  assign q = sync_q;

endmodule

// File: rtl/sf_mode_ctl.sv
`timescale 1ns/1ps
// Mode register, configuration change detection and width lookup.
module sf_mode_ctl
  import spike_filter_pkg::*;
#(
  parameter int unsigned W_VNARROW   = 1,
  parameter int unsigned W_NARROW    = 5,
  parameter int unsigned W_WIDE      = 10,
  parameter int unsigned SETTLE_MULT = 10,
  parameter int unsigned SPAN_W      = 4,
  parameter int unsigned LIM_W       = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              mode_load,
  input  logic [1:0]        mode_wdata,
  input  logic              i2c_sel,
  input  logic              clk_pol,
  output fmode_e            mode,
  output logic              bypass,
  output logic              mode_chg,
  output logic              cfg_chg,
  output logic [SPAN_W-1:0] span,
  output logic [LIM_W-1:0]  limit
);

  localparam int unsigned LIM_VN = SETTLE_MULT * W_VNARROW;
  localparam int unsigned LIM_N  = SETTLE_MULT * W_NARROW;
  localparam int unsigned LIM_W_ = SETTLE_MULT * W_WIDE;

  fmode_e mode_q, mode_d;
  logic   mode_en;
  logic   i2c_q, pol_q;
  logic   side_chg;

  // next state
  always_comb begin
    mode_en = soft_rst | mode_load;
    if (soft_rst) mode_d = FM_BYPASS;
    else          mode_d = fmode_e'(mode_wdata);
  end

  always_comb begin
    mode_chg = !soft_rst && mode_load && (mode_wdata != 2'(mode_q));
    side_chg = !soft_rst && ((i2c_sel != i2c_q) || (clk_pol != pol_q));
    cfg_chg  = mode_chg | side_chg;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= FM_BYPASS;
    end else if (mode_en) begin
      mode_q <= mode_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i2c_q <= 1'b0;
      pol_q <= 1'b0;
    end else begin
      i2c_q <= i2c_sel;
      pol_q <= clk_pol;
    end
  end

  // width lookup from the active mode
  always_comb begin
    case (mode_q)
      FM_VNARROW: begin span = SPAN_W'(W_VNARROW); limit = LIM_W'(LIM_VN); end
      FM_NARROW:  begin span = SPAN_W'(W_NARROW);  limit = LIM_W'(LIM_N);  end
      FM_WIDE:    begin span = SPAN_W'(W_WIDE);    limit = LIM_W'(LIM_W_); end
      default:    begin span = '0;                 limit = '0;             end
    endcase
  end

  assign mode   = mode_q;
  assign bypass = (mode_q == FM_BYPASS);

endmodule

// File: rtl/sf_stab_filter.sv
`timescale 1ns/1ps
// Per-line stability counter: accept a level after span+1 equal samples.
module sf_stab_filter #(
  parameter int unsigned SPAN_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              bypass,
  input  logic              restart,
  input  logic [SPAN_W-1:0] span,
  input  logic              s_in,
  output logic              f_out
);

  logic [SPAN_W-1:0] cnt_q, cnt_d;
  logic              lvl_q, lvl_d;

  always_comb begin
    cnt_d = cnt_q;
    lvl_d = lvl_q;
    if (clr) begin
      cnt_d = '0;
      lvl_d = 1'b1;
    end else if (bypass) begin
      cnt_d = '0;
      lvl_d = s_in;
    end else if (restart || (s_in == lvl_q)) begin
      cnt_d = '0;
    end else if (cnt_q == span) begin
      cnt_d = '0;
      lvl_d = s_in;
    end else begin
      cnt_d = cnt_q + SPAN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  assign f_out = bypass ? s_in : lvl_q;

endmodule

// File: rtl/sf_settle_timer.sv
`timescale 1ns/1ps
// Settle window timer shared by both lines.
module sf_settle_timer #(
  parameter int unsigned LIM_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             trig,
  input  logic             bypass,
  input  logic [LIM_W-1:0] limit,
  output logic             settled
);

  logic             busy_q, busy_d;
  logic [LIM_W-1:0] tcnt_q, tcnt_d;

  always_comb begin
    busy_d = busy_q;
    tcnt_d = tcnt_q;
    if (clr) begin
      busy_d = 1'b0;
      tcnt_d = '0;
    end else if (trig) begin
      busy_d = 1'b1;
      tcnt_d = '0;
    end else if (bypass) begin
      busy_d = 1'b0;
      tcnt_d = '0;
    end else if (busy_q) begin
      if (tcnt_q == limit - LIM_W'(1)) begin
        busy_d = 1'b0;
        tcnt_d = '0;
      end else begin
        tcnt_d = tcnt_q + LIM_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      tcnt_q <= '0;
    end else begin
      busy_q <= busy_d;
      tcnt_q <= tcnt_d;
    end
  end

  assign settled = bypass | ~busy_q;

endmodule

// File: rtl/spike_filter.sv
`timescale 1ns/1ps
module spike_filter
  import spike_filter_pkg::*;
#(
  parameter int unsigned W_VNARROW   = 1,
  parameter int unsigned W_NARROW    = 5,
  parameter int unsigned W_WIDE      = 10,
  parameter int unsigned SETTLE_MULT = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  logic       line_clk_in,
  input  logic       line_dat_in,
  input  logic       mode_load,
  input  logic [1:0] mode_wdata,
  input  logic       i2c_sel,
  input  logic       clk_pol,
  output logic       line_clk_out,
  output logic       line_dat_out,
  output logic       settled
);

  localparam int unsigned SPAN_W = $clog2(W_WIDE + 1);
  localparam int unsigned LIM_W  = $clog2(SETTLE_MULT * W_WIDE + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  fmode_e              mode_q;
  logic                bypass;
  logic                mode_chg;
  logic                cfg_chg;
  logic [SPAN_W-1:0]   span;
  logic [LIM_W-1:0]    limit;
  logic [NUM_LINES-1:0] raw_vec;
  logic [NUM_LINES-1:0] s_vec;
  logic [NUM_LINES-1:0] filt_vec;

  assign raw_vec[LINE_CLK] = line_clk_in;
  assign raw_vec[LINE_DAT] = line_dat_in;

  sf_mode_ctl #(
    .W_VNARROW  (W_VNARROW),
    .W_NARROW   (W_NARROW),
    .W_WIDE     (W_WIDE),
    .SETTLE_MULT(SETTLE_MULT),
    .SPAN_W     (SPAN_W),
    .LIM_W      (LIM_W)
  ) u_mode (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .soft_rst  (soft_rst),
    .mode_load (mode_load),
    .mode_wdata(mode_wdata),
    .i2c_sel   (i2c_sel),
    .clk_pol   (clk_pol),
    .mode      (mode_q),
    .bypass    (bypass),
    .mode_chg  (mode_chg),
    .cfg_chg   (cfg_chg),
    .span      (span),
    .limit     (limit)
  );

  sf_sync2 #(.WIDTH(NUM_LINES)) u_sync (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .clr  (soft_rst),
    .d    (raw_vec),
    .q    (s_vec)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    sf_stab_filter #(.SPAN_W(SPAN_W)) u_filt (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .clr    (soft_rst),
      .bypass (bypass),
      .restart(mode_chg),
      .span   (span),
      .s_in   (s_vec[g]),
      .f_out  (filt_vec[g])
    );
  end

  sf_settle_timer #(.LIM_W(LIM_W)) u_settle (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clr    (soft_rst),
    .trig   (cfg_chg),
    .bypass (bypass),
    .limit  (limit),
    .settled(settled)
  );

  assign line_clk_out = filt_vec[LINE_CLK];
  assign line_dat_out = filt_vec[LINE_DAT];

endmodule

// File: rtl/sf_checker.sv
`timescale 1ns/1ps
module sf_checker #(
  parameter int unsigned W_VNARROW   = 1,
  parameter int unsigned W_NARROW    = 5,
  parameter int unsigned W_WIDE      = 10,
  parameter int unsigned SETTLE_MULT = 10
) (
  input logic       clk,
  input logic       rst_n,
  input logic       soft_rst,
  input logic       mode_load,
  input logic       line_dat_in,
  input logic       s_dat,
  input logic       line_dat_out,
  input logic       line_clk_out,
  input logic       settled,
  input logic [1:0] mode,
  input logic       cfg_chg
);

  logic [1:0]  age_q;
  logic [31:0] lowcnt_q;

  function automatic logic [31:0] window_of(input logic [1:0] m);
    case (m)
      2'b01:   return 32'(SETTLE_MULT * W_VNARROW);
      2'b10:   return 32'(SETTLE_MULT * W_NARROW);
      2'b11:   return 32'(SETTLE_MULT * W_WIDE);
      default: return 32'd0;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               age_q <= 2'd0;
    else if (age_q != 2'd3)   age_q <= age_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lowcnt_q <= 32'd0;
    else if (cfg_chg)  lowcnt_q <= 32'd1;
    else if (!settled) lowcnt_q <= lowcnt_q + 32'd1;
  end

  // R2: software reset returns idle-high outputs in bypass
  a_r2_soft_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (line_clk_out && line_dat_out && settled && mode == 2'b00));

  // R3: bypass output is the pin two cycles earlier
  a_r3_bypass_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3 && mode == 2'b00 && !$past(soft_rst) && !$past(soft_rst, 2))
      |-> (line_dat_out == $past(line_dat_in, 2)));

  // R4: a filtered output only moves after at least two agreeing samples
  a_r4_min_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3 && mode != 2'b00 && $past(mode) != 2'b00 && !$past(soft_rst)
      && line_dat_out != $past(line_dat_out))
      |-> ($past(s_dat) == line_dat_out && $past(s_dat, 2) == line_dat_out));

  // R7: a config change in a filtered mode drops the flag next cycle
  a_r7_flag_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_chg && !soft_rst && !(mode == 2'b00 && !mode_load)) |=> (!settled || mode == 2'b00));

  // R7: the low window length matches the active mode
  a_r7_window_len: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(settled) && mode != 2'b00) |-> (lowcnt_q == window_of(mode) + 32'd1));

  // R11: the mode holds without a load strobe
  a_r11_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q != 2'd0 && !mode_load && !soft_rst) |=> $stable(mode));

endmodule

bind spike_filter sf_checker #(
  .W_VNARROW  (W_VNARROW),
  .W_NARROW   (W_NARROW),
  .W_WIDE     (W_WIDE),
  .SETTLE_MULT(SETTLE_MULT)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .soft_rst    (soft_rst),
  .mode_load   (mode_load),
  .line_dat_in (line_dat_in),
  .s_dat       (s_vec[1]),
  .line_dat_out(line_dat_out),
  .line_clk_out(line_clk_out),
  .settled     (settled),
  .mode        (mode_q),
  .cfg_chg     (cfg_chg)
);

// File: tb/spike_filter_test.sv
`timescale 1ns/1ps
module spike_filter_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       soft_rst;
  logic       line_clk_in, line_dat_in;
  logic       mode_load;
  logic [1:0] mode_wdata;
  logic       i2c_sel, clk_pol;
  logic       line_clk_out, line_dat_out, settled;

  int cyc = 0;
  int checks = 0;
  int errors = 0;

  localparam int SIG_CLK = 0;
  localparam int SIG_DAT = 1;
  localparam int SIG_SET = 2;

  typedef struct {
    int    due;
    int    sig;
    logic  val;
    string tag;
  } exp_t;

  exp_t sbq[$];

  spike_filter uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .line_clk_in (line_clk_in),
    .line_dat_in (line_dat_in),
    .mode_load   (mode_load),
    .mode_wdata  (mode_wdata),
    .i2c_sel     (i2c_sel),
    .clk_pol     (clk_pol),
    .line_clk_out(line_clk_out),
    .line_dat_out(line_dat_out),
    .settled     (settled)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic pick(input int sig);
    case (sig)
      SIG_CLK: return line_clk_out;
      SIG_DAT: return line_dat_out;
      default: return settled;
    endcase
  endfunction

  // driver side: queue an expected value for a given cycle
  task automatic expect_at(input int due, input int sig, input logic val, input string tag);
    exp_t e;
    int   i;
    e.due = due; e.sig = sig; e.val = val; e.tag = tag;
    i = 0;
    while (i < sbq.size() && sbq[i].due <= due) i++;
    sbq.insert(i, e);
  endtask

  // monitor: compare due items away from the active edge
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].due <= cyc) begin
      exp_t e;
      e = sbq.pop_front();
      checks++;
      if (e.due < cyc || pick(e.sig) !== e.val) begin
        errors++;
        $display("FAIL %s sig %0d cycle %0d actual %b expected %b",
                 e.tag, e.sig, cyc, pick(e.sig), e.val);
      end
    end
  end

  task automatic check_now(input int sig, input logic val, input string tag);
    checks++;
    if (pick(sig) !== val) begin
      errors++;
      $display("FAIL %s sig %0d actual %b expected %b", tag, sig, pick(sig), val);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_line(input int sig, input logic v);
    if (sig == SIG_CLK) line_clk_in = v;
    else                line_dat_in = v;
  endtask

  function automatic int window(input logic [1:0] m);
    case (m)
      2'b01:   return 10;
      2'b10:   return 50;
      2'b11:   return 100;
      default: return 0;
    endcase
  endfunction

  // load a filtered mode that differs from the current one (R7)
  task automatic load_mode(input logic [1:0] m);
    int n;
    int w;
    n = cyc;
    w = window(m);
    mode_wdata = m;
    mode_load  = 1'b1;
    expect_at(n + 1, SIG_SET, 1'b0, "R7 flag drops");
    expect_at(n + w, SIG_SET, 1'b0, "R7 flag still low");
    expect_at(n + w + 1, SIG_SET, 1'b1, "R7 flag rises");
    tick(1);
    mode_load = 1'b0;
    tick(w + 3);
  endtask

  // low pulse of len cycles on one pin; wd is the width, -1 for bypass
  task automatic pulse(input int sig, input int len, input int wd, input string tag);
    int n;
    n = cyc;
    if (len > wd) begin
      expect_at(n + wd + 2, sig, 1'b1, tag);
      expect_at(n + wd + 3, sig, 1'b0, tag);
      expect_at(n + len + wd + 2, sig, 1'b0, tag);
      expect_at(n + len + wd + 3, sig, 1'b1, tag);
    end else begin
      expect_at(n + wd + 3, sig, 1'b1, tag);
      expect_at(n + len + wd + 3, sig, 1'b1, tag);
    end
    set_line(sig, 1'b0);
    tick(len);
    set_line(sig, 1'b1);
    tick(wd + 8);
  endtask

  // toggle a side control and expect a settle window of w cycles
  task automatic toggle_side(input bit use_pol, input int w, input string tag);
    int n;
    n = cyc;
    if (use_pol) clk_pol = ~clk_pol;
    else         i2c_sel = ~i2c_sel;
    expect_at(n + 1, SIG_SET, 1'b0, tag);
    expect_at(n + w, SIG_SET, 1'b0, tag);
    expect_at(n + w + 1, SIG_SET, 1'b1, tag);
    tick(w + 3);
  endtask

  initial begin
    int n;
    rst_n = 1'b0; soft_rst = 1'b0;
    line_clk_in = 1'b0; line_dat_in = 1'b0;
    mode_load = 1'b0; mode_wdata = 2'b00;
    i2c_sel = 1'b0; clk_pol = 1'b0;
    tick(4);
    // R1: idle-high outputs and settled while held in reset, pins low
    check_now(SIG_CLK, 1'b1, "R1 reset clk line");
    check_now(SIG_DAT, 1'b1, "R1 reset dat line");
    check_now(SIG_SET, 1'b1, "R1 reset settled");
    line_clk_in = 1'b1; line_dat_in = 1'b1;
    rst_n = 1'b1;
    tick(6);

    // R3: bypass passes single-cycle pulses with two cycles latency
    pulse(SIG_DAT, 1, -1, "R3 bypass dat pulse");
    pulse(SIG_CLK, 1, -1, "R3 bypass clk pulse");
    pulse(SIG_DAT, 3, -1, "R3 bypass dat wide");

    // R9: side controls do not lower the flag in bypass
    n = cyc;
    clk_pol = 1'b1;
    expect_at(n + 1, SIG_SET, 1'b1, "R9 bypass pol");
    expect_at(n + 3, SIG_SET, 1'b1, "R9 bypass pol");
    tick(4);

    // R4: very narrow width 1
    load_mode(2'b01);
    pulse(SIG_DAT, 1, 1, "R4 reject 1");
    pulse(SIG_DAT, 2, 1, "R4 accept 2");
    pulse(SIG_CLK, 1, 1, "R4 reject clk 1");
    pulse(SIG_CLK, 2, 1, "R4 accept clk 2");

    // R11: data without strobe is ignored; filtering stays at width 1
    n = cyc;
    mode_wdata = 2'b00;
    expect_at(n + 1, SIG_SET, 1'b1, "R11 no strobe");
    tick(2);
    pulse(SIG_DAT, 1, 1, "R11 still filtering");

    // R8: polarity change in filtered mode
    toggle_side(1'b1, 10, "R8 pol window");

    // R10: change on the last low cycle restarts the window
    n = cyc;
    clk_pol = ~clk_pol;
    expect_at(n + 1, SIG_SET, 1'b0, "R10 first window");
    expect_at(n + 10, SIG_SET, 1'b0, "R10 first window");
    expect_at(n + 11, SIG_SET, 1'b0, "R10 restart");
    expect_at(n + 20, SIG_SET, 1'b0, "R10 restart");
    expect_at(n + 21, SIG_SET, 1'b1, "R10 restart ends");
    tick(10);
    i2c_sel = ~i2c_sel;
    tick(14);

    // R5: narrow width 5
    load_mode(2'b10);
    pulse(SIG_DAT, 5, 5, "R5 reject 5");
    pulse(SIG_DAT, 6, 5, "R5 accept 6");
    pulse(SIG_CLK, 6, 5, "R5 accept clk 6");
    n = cyc;
    expect_at(n + 8, SIG_DAT, 1'b1, "R5 broken pulse");
    expect_at(n + 17, SIG_DAT, 1'b1, "R5 broken pulse");
    line_dat_in = 1'b0; tick(4);
    line_dat_in = 1'b1; tick(1);
    line_dat_in = 1'b0; tick(4);
    line_dat_in = 1'b1; tick(14);

    // R6: wide width 10
    load_mode(2'b11);
    pulse(SIG_DAT, 10, 10, "R6 reject 10");
    pulse(SIG_DAT, 11, 10, "R6 accept 11");
    pulse(SIG_CLK, 10, 10, "R6 reject clk 10");

    // R8: protocol select change in wide mode
    toggle_side(1'b0, 100, "R8 i2c window");

    // R2: software reset from wide mode with data held low
    n = cyc;
    line_dat_in = 1'b0;
    expect_at(n + 13, SIG_DAT, 1'b0, "R6 long low accepted");
    tick(20);
    n = cyc;
    soft_rst = 1'b1;
    expect_at(n + 1, SIG_DAT, 1'b1, "R2 dat idle");
    expect_at(n + 1, SIG_CLK, 1'b1, "R2 clk idle");
    expect_at(n + 1, SIG_SET, 1'b1, "R2 settled");
    expect_at(n + 3, SIG_DAT, 1'b0, "R2 bypass follows");
    tick(1);
    soft_rst = 1'b0;
    tick(4);
    line_dat_in = 1'b1;
    tick(4);
    pulse(SIG_DAT, 1, -1, "R2 mode is bypass");

    tick(5);
    while (sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      checks++;
      errors++;
      $display("FAIL %s never checked actual none expected %b", e.tag, e.val);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog all requirements actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule